// File: doc/BRIEF.md
# IDE Interrupt Status and Sticky Enable

This block gathers the interrupt request lines of up to three IDE ports, resynchronises them to the local clock, and presents the level of each line as a status byte. Software reads these bytes to find out which port raised the shared host interrupt. Each port's status byte answers in a 64-byte window, so every address inside the window returns the same byte. A strap input picks the two-port or the three-port build of the board. In the two-port build the third port is treated as absent: its status always reads as idle, and its line never reaches the host.

The combined interrupt is held off the host bus until software performs one write, with any data, into the enable window. Some drives pull their interrupt line active while they power up, and this hold-off keeps them from stalling the host during boot. After the write the enable stays set until reset. It cannot be cleared by software and it cannot be read back.

Top module: `ide_irq_gate`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` is 0x00, `host_irq` is 0, and the enable is clear.
- R2: Each `irq_raw` bit passes through a two-flop synchroniser. The status seen by a read and by `host_irq` is the input level sampled two clock edges earlier.
- R3: With `rd_en` high in a cycle, `rd_data` in the next cycle holds port 0's synchronised level in bit 7 for any address 0xF00 to 0xF3F. Bits 6 to 0 of every status read are 0.
- R4: A read of any address 0xF40 to 0xF7F returns port 1's synchronised level in bit 7.
- R5: A read of any address 0xF80 to 0xFBF returns port 2's synchronised level in bit 7 when `three_port` is 1, and 0x00 when `three_port` is 0.
- R6: A read of any address outside 0xF00 to 0xFBF returns 0x00, and this includes the enable window 0xFC0 to 0xFFF. In a cycle that follows one without `rd_en`, `rd_data` is 0x00.
- R7: While the enable is clear, `host_irq` stays 0 whatever the IRQ lines do.
- R8: `wr_en` with any address 0xFC0 to 0xFFF sets the enable at that clock edge. Writes to any other address have no effect.
- R9: Once the enable is set, `host_irq` equals the OR of the synchronised levels of the active ports. The enable stays set until reset, whatever is written afterwards.
- R10: When `three_port` is 0, port 2's line never drives `host_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| three_port | input | 1 | Build strap: 1 selects three ports, 0 selects two |
| irq_raw | input | 3 | Asynchronous IRQ lines from ports 0 to 2, active high |
| addr | input | 12 | Local byte offset of the access |
| rd_en | input | 1 | Read strobe; data returns in the next cycle |
| wr_en | input | 1 | Write strobe; data value is irrelevant |
| rd_data | output | 8 | Registered read data |
| host_irq | output | 1 | Gated, combined interrupt request to the host bus |

## Verification
The bench builds the block with its default parameters: three ports, a 12-bit offset, 64-byte windows and a two-stage synchroniser. These settings put the window edges 0xF3F, 0xF40, 0xFBF and 0xFC0 within reach, along with both strap settings and the full three-cycle path from an IRQ edge to a status read. Because the reset pulse is repeated, the bench also shows that the sticky enable returns to its blocking state, and that IRQs held active before the enable write stay off the host bus.

// File: rtl/ide_irq_pkg.sv
// Package: shared constants and window codes for the IDE interrupt gate.
// Assumes the enable window is the last window of the status page.
package ide_irq_pkg;

    // Window selector inside the 0xF00 status page (two address bits).
    typedef enum logic [1:0] {
        WIN_PORT0  = 2'd0,
        WIN_PORT1  = 2'd1,
        WIN_PORT2  = 2'd2,
        WIN_ENABLE = 2'd3
    } win_sel_t;

    localparam int WIN_BITS = 2;

endpackage

// File: rtl/ide_irq_sync.sv
// Module: multi-bit synchroniser, one independent chain per bit.
// Assumes each bit is an unrelated level; no bus coherence is implied.
module ide_irq_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the level one stage further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else if (s == 0) chain[s] <= d_async;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/ide_irq_decode.sv
// Module: status-page decoder and registered read port.
// Assumes the page is selected by all-ones upper offset bits and each
// window covers 2**WIN_LSB bytes; the last window is the enable window.
module ide_irq_decode
    import ide_irq_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 12,
    parameter int WIN_LSB   = 6,
    parameter int DATA_W    = 8,
    localparam int HI_W     = ADDR_W - WIN_LSB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HI_W-1:0]      addr_hi,
    input  logic                 rd_en,
    input  logic [NUM_PORTS-1:0] lvl,
    input  logic [NUM_PORTS-1:0] port_mask,
    output logic                 enable_hit,
    output logic [DATA_W-1:0]    rd_data
);
    logic                page_hit;
    win_sel_t            win;
    logic [DATA_W-1:0]   rd_next;

    // Decode the page and window fields of the offset.
    always_comb begin
        page_hit   = &addr_hi[HI_W-1:WIN_BITS];
        win        = win_sel_t'(addr_hi[WIN_BITS-1:0]);
        enable_hit = page_hit && (win == WIN_ENABLE);
    end

    // Select the status bit of the addressed port, masked by the strap.
    always_comb begin
        rd_next = '0;
        if (rd_en && page_hit) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (int'(win) == p)
                    rd_next[DATA_W-1] = lvl[p] & port_mask[p];
            end
        end
    end

    // Register the read data for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_next;
    end
endmodule

// File: rtl/ide_irq_enable.sv
// Module: set-only enable flag; cleared by reset only.
// Assumes the caller qualifies the set pulse with the address decode.
module ide_irq_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    output logic en_q
);
    // Latch the enable on the first qualifying write and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (set_req) en_q <= 1'b1;
    end
endmodule

// File: rtl/ide_irq_gate.sv
// Module: IDE interrupt status page and sticky host-interrupt gate.
// Assumes irq_raw is asynchronous and active high, and that the strap
// three_port is static in normal use (it is sampled combinationally).
module ide_irq_gate #(
    parameter int NUM_PORTS   = 3,
    parameter int ADDR_W      = 12,
    parameter int WIN_LSB     = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 three_port,
    input  logic [NUM_PORTS-1:0] irq_raw,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd_en,
    input  logic                 wr_en,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 host_irq
);
    localparam int HI_W = ADDR_W - WIN_LSB;

    logic [NUM_PORTS-1:0] sync_lvl;
    logic [NUM_PORTS-1:0] port_mask;
    logic                 enable_hit;
    logic                 en_q;
    logic                 unused_low_addr;

    assign unused_low_addr = ^addr[WIN_LSB-1:0];

    // The two-port build drops the highest port from status and interrupt.
    always_comb begin
        port_mask = '1;
        if (!three_port) port_mask[NUM_PORTS-1] = 1'b0;
    end

    ide_irq_sync #(.WIDTH(NUM_PORTS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (irq_raw),
        .q_sync  (sync_lvl)
    );

    ide_irq_decode #(
        .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W),
        .WIN_LSB(WIN_LSB), .DATA_W(DATA_W)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_hi    (addr[ADDR_W-1:WIN_LSB]),
        .rd_en      (rd_en),
        .lvl        (sync_lvl),
        .port_mask  (port_mask),
        .enable_hit (enable_hit),
        .rd_data    (rd_data)
    );

    ide_irq_enable u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (wr_en && enable_hit),
        .en_q    (en_q)
    );

    // Combine the active ports and gate them with the sticky enable.
    always_comb host_irq = en_q && |(sync_lvl & port_mask);
endmodule

// File: rtl/ide_irq_gate_chk.sv
// Module: property checker for ide_irq_gate, attached with bind.
// Assumes the default 64-byte windows with the enable window last.
module ide_irq_gate_chk #(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 12,
    parameter int WIN_LSB   = 6,
    parameter int DATA_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 three_port,
    input logic [NUM_PORTS-1:0] irq_raw,
    input logic [ADDR_W-1:0]    addr,
    input logic                 rd_en,
    input logic                 wr_en,
    input logic [DATA_W-1:0]    rd_data,
    input logic                 host_irq,
    input logic                 en_q,
    input logic [NUM_PORTS-1:0] sync_lvl
);
    p_sync_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2)) |-> (sync_lvl == $past(irq_raw, 2)));

    p_low_bits_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-2:0] == '0);

    p_idle_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

    p_enable_window_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (&addr[ADDR_W-1:WIN_LSB])) |=> (rd_data == '0));

    p_gate_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> en_q);

    p_enable_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (&addr[ADDR_W-1:WIN_LSB])) |=> en_q);

    p_enable_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);

    p_port2_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && !three_port) |-> (|sync_lvl[NUM_PORTS-2:0]));
endmodule

bind ide_irq_gate ide_irq_gate_chk #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/test_ide_irq_gate.sv
// Bench: behavioural reference model compared with the outputs every cycle.
module test_ide_irq_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        three_port = 1'b1;
    logic [2:0]  irq_raw = '0;
    logic [11:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  rd_data;
    logic        host_irq;

    int    tests = 0;
    int    fails = 0;
    string cur_req = "R1";

    // Reference model state: history of the last two sampled IRQ vectors.
    bit [2:0] hist[$];
    bit       m_en = 0;
    bit [7:0] m_rd = 0;

    always #2.5 clk = ~clk;

    ide_irq_gate i_ide_irq_gate (
        .clk(clk), .rst_n(rst_n), .three_port(three_port), .irq_raw(irq_raw),
        .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .rd_data(rd_data), .host_irq(host_irq)
    );

    function automatic bit [7:0] status_of(bit [11:0] a, bit [2:0] lv, bit three);
        if (a >= 12'hF00 && a <= 12'hF3F) return {lv[0], 7'd0};
        if (a >= 12'hF40 && a <= 12'hF7F) return {lv[1], 7'd0};
        if (a >= 12'hF80 && a <= 12'hFBF) return three ? {lv[2], 7'd0} : 8'h00;
        return 8'h00;
    endfunction

    initial begin
        hist.push_back(3'b000);
        hist.push_back(3'b000);
    end

    // Advance the model on each rising edge with the inputs held since the last fall.
    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            hist.push_back(3'b000);
            hist.push_back(3'b000);
            m_en = 0;
            m_rd = 0;
        end else begin
            m_rd = rd_en ? status_of(addr, hist[0], three_port) : 8'h00;
            if (wr_en && addr >= 12'hFC0) m_en = 1;
            void'(hist.pop_front());
            hist.push_back(irq_raw);
        end
    end

    task automatic compare();
        bit [2:0] mask;
        bit       exp_irq;
        mask    = three_port ? 3'b111 : 3'b011;
        exp_irq = m_en && |(hist[0] & mask);
        tests++;
        if (rd_data !== m_rd) begin
            fails++;
            $display("FAIL %s rd_data actual=%02h expected=%02h", cur_req, rd_data, m_rd);
        end
        tests++;
        if (host_irq !== exp_irq) begin
            fails++;
            $display("FAIL %s host_irq actual=%0b expected=%0b", cur_req, host_irq, exp_irq);
        end
    endtask

    // One cycle: check the outputs, then drive the next inputs.
    task automatic cyc(input bit r, input bit w, input bit [11:0] a,
                       input bit [2:0] irq, input bit three, input string req);
        @(negedge clk);
        compare();
        rd_en = r; wr_en = w; addr = a; irq_raw = irq; three_port = three;
        cur_req = req;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rd_en = 0; wr_en = 0; irq_raw = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
    endtask

    initial begin : watchdog
        #200000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1: idle after reset
        repeat (3) cyc(0, 0, 12'h000, 3'b000, 1, "R1");

        // R7: drives hold IRQ high before enable; host must stay quiet
        repeat (4) cyc(0, 0, 12'h000, 3'b111, 1, "R7");

        // R3/R4/R5: status windows and their mirrors, three-port build
        cyc(1, 0, 12'hF00, 3'b101, 1, "R3");
        cyc(1, 0, 12'hF3F, 3'b101, 1, "R3");
        cyc(1, 0, 12'hF40, 3'b101, 1, "R4");
        cyc(1, 0, 12'hF7F, 3'b101, 1, "R4");
        cyc(1, 0, 12'hF80, 3'b101, 1, "R5");
        cyc(1, 0, 12'hFBF, 3'b101, 1, "R5");
        cyc(1, 0, 12'hF55, 3'b101, 1, "R4");
        // R5: two-port build hides port 2
        cyc(1, 0, 12'hF80, 3'b111, 0, "R5");
        cyc(1, 0, 12'hF9A, 3'b111, 0, "R5");

        // R6: reads outside the status windows, enable window included
        cyc(1, 0, 12'hFC0, 3'b111, 1, "R6");
        cyc(1, 0, 12'hFFF, 3'b111, 1, "R6");
        cyc(1, 0, 12'hEFF, 3'b111, 1, "R6");
        cyc(1, 0, 12'h000, 3'b111, 1, "R6");
        cyc(0, 0, 12'hF00, 3'b111, 1, "R6");

        // R2: alternating IRQ patterns read back every cycle
        for (int i = 0; i < 12; i++)
            cyc(1, 0, (i % 3 == 0) ? 12'hF00 : (i % 3 == 1) ? 12'hF40 : 12'hF80,
                3'(i * 5), 1, "R2");

        // R8: writes outside the enable window leave the gate closed
        cyc(0, 1, 12'hF00, 3'b111, 1, "R8");
        cyc(0, 1, 12'hFBF, 3'b111, 1, "R8");
        cyc(0, 1, 12'h7C0, 3'b111, 1, "R8");
        cyc(0, 0, 12'h000, 3'b111, 1, "R8");
        // R8: a write inside the enable window opens it
        cyc(0, 1, 12'hFE3, 3'b111, 1, "R8");
        cyc(0, 0, 12'h000, 3'b111, 1, "R8");

        // R9: OR of active ports follows the synchronised levels
        for (int i = 0; i < 16; i++)
            cyc(i[0], i[1], 12'hF00 + 12'(i * 16), 3'(i), 1, "R9");
        cyc(0, 1, 12'hFFF, 3'b000, 1, "R9");
        repeat (3) cyc(0, 0, 12'h000, 3'b010, 1, "R9");

        // R10: port 2 alone never reaches the host in the two-port build
        repeat (4) cyc(0, 0, 12'h000, 3'b100, 0, "R10");
        cyc(0, 0, 12'h000, 3'b100, 1, "R10");
        cyc(0, 0, 12'h000, 3'b100, 0, "R10");
        cyc(0, 0, 12'h000, 3'b101, 0, "R10");
        repeat (3) cyc(1, 0, 12'hF80, 3'b101, 0, "R10");

        // R1: reset clears the sticky enable again
        do_reset();
        repeat (5) cyc(0, 0, 12'h000, 3'b111, 1, "R1");
        cyc(1, 0, 12'hF40, 3'b111, 1, "R1");
        cyc(0, 0, 12'h000, 3'b000, 1, "R1");
        @(negedge clk);
        compare();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule